// File: doc/BRIEF.md
# Prescaled Clock Divider with Glitch-Free Output Gating

This block derives an output clock from a master oscillator. The master clock first passes through a prescaler that divides by 1, 2 or 4, and the result is brought out as `mclk_out`. That prescaled clock then drives a programmable integer divider whose ratio is a 9-bit code plus two. Alternatively, the divider can be skipped so that the prescaled clock reaches `clk_out` directly. An asynchronous enable gates `clk_out`. Gating acts only at clock boundaries, so a high pulse is never cut short and a pulse is never started halfway. While the output is gated off, the divider counter is held at zero, so the phase after re-enable is always the same.

The whole block runs on one register clock, `clk`, which acts as a half-period timebase for the oscillator. One `clk` cycle is the shortest high or low phase the block can produce. Undivided, the oscillator therefore toggles once per `clk` cycle, and every output is a registered level. Configuration inputs are static while the block runs. They are changed only while `rst_n` is low.

Top module: `gated_prescale_div`

## Requirements
- R1: `mclk_out` is high for P cycles of `clk` and then low for P cycles, with P=1 when `cfg_pre_bypass`=1, P=2 when `cfg_pre_bypass`=0 and `cfg_m`=1, and P=4 when `cfg_pre_bypass`=0 and `cfg_m`=0. The enable has no effect on it.
- R2: With `cfg_div_bypass`=0 and the block enabled, `clk_out` repeats every D prescaled periods, where D = `cfg_n` + 2 (2 to 513), that is D*2P cycles of `clk`.
- R3: In divide mode each high phase of `clk_out` lasts floor(D/2) prescaled periods, and the low phase takes the remainder. Even D gives equal halves, and for odd D the low phase is one prescaled period longer.
- R4: `clk_out` rises only in a cycle in which `mclk_out` also rises.
- R5: With `cfg_div_bypass`=1 and the block enabled, `clk_out` follows `mclk_out` exactly (high P cycles, low P cycles) whatever `cfg_n` holds.
- R6: The enable is retimed by two stages clocked at rising edges of `mclk_out`. Once the enable goes high between edges while the output is idle, `clk_out` stays low through the first two rising edges of `mclk_out` and rises together with the third.
- R7: In divide mode, dropping the enable never shortens a high pulse: a pulse in progress runs to its full floor(D/2)*2P cycles, after which `clk_out` stays low. Dropping the enable during a low phase of at least three prescaled periods produces no further pulse.
- R8: In divide-by-one mode (`cfg_div_bypass`=1), dropping the enable between edges lets exactly two more full pulses start, after which `clk_out` stays low.
- R9: While `rst_n` is low both outputs are low. After reset with the enable low, `clk_out` stays low while `mclk_out` keeps toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-period timebase of the master oscillator; all registers use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_m | input | 1 | Prescaler ratio select: 1 gives divide-by-2, 0 gives divide-by-4 |
| cfg_pre_bypass | input | 1 | 1 skips the prescaler (divide-by-1) |
| cfg_div_bypass | input | 1 | 1 routes the prescaled clock to `clk_out`, ignoring `cfg_n` |
| cfg_n | input | NW (9) | Divider code; divisor is this value plus two |
| enable_async | input | 1 | Asynchronous active-high output enable |
| clk_out | output | 1 | Gated, divided output clock |
| mclk_out | output | 1 | Prescaled master clock, never gated |

## Verification
The period and duty checks use divider codes that give an even divisor (2 and 6), odd divisors (3 and 7) and the largest divisor (513), each combined with a different prescaler ratio. Comparing the odd cases with the even ones shows whether the short phase is placed high. The largest code catches any truncation of the divider counter. Two divide-by-one settings with different codes, one of them zero, show that the code is ignored in that mode. The gating tests drop the enable in the middle of a high pulse and again just after a falling edge, then re-enable after each. This separates a gate that cuts pulses from one that waits for them, and it shows that the counter restarts from a fixed phase.

// File: rtl/gdiv_pkg.sv
package gdiv_pkg;

   typedef enum logic [1:0] {
      PS_BY1 = 2'd0,
      PS_BY2 = 2'd1,
      PS_BY4 = 2'd2
   } ps_sel_e;

   localparam int PS_MAX_HALF = 4;
   localparam int PH_W        = $clog2(2 * PS_MAX_HALF);

   function automatic ps_sel_e ps_decode(input logic pre_bypass, input logic m_bit);
      if (pre_bypass)  return PS_BY1;
      else if (m_bit)  return PS_BY2;
      else             return PS_BY4;
   endfunction

   function automatic logic [PH_W-1:0] ps_half(input ps_sel_e sel);
      case (sel)
         PS_BY2:  return PH_W'(2);
         PS_BY4:  return PH_W'(4);
         default: return PH_W'(1);
      endcase
   endfunction

endpackage

// File: rtl/gpd_prescaler.sv
module gpd_prescaler
   import gdiv_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  ps_sel_e sel,
   output logic    mclk_tick,
   output logic    mclk_nxt,
   output logic    mclk_q
);
   logic [PH_W-1:0] half_len;
   logic [PH_W-1:0] last_ph;
   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] ph_nxt;

   always_comb begin
      half_len  = ps_half(sel);
      last_ph   = PH_W'((half_len << 1) - PH_W'(1));
      // wrap on >= so a phase left over from a larger ratio cannot stall
      mclk_tick = (ph_q >= last_ph);
      ph_nxt    = mclk_tick ? '0 : ph_q + PH_W'(1);
      mclk_nxt  = (ph_nxt < half_len);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= '1;
         mclk_q <= 1'b0;
      end else begin
         ph_q   <= ph_nxt;
         mclk_q <= mclk_nxt;
      end
   end
endmodule

// File: rtl/gpd_en_sync.sv
module gpd_en_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mclk_tick,
   input  logic en_async,
   output logic en_ok
);
   logic [STAGES-1:0] stg_q;

   generate
      for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)         stg_q[gi] <= 1'b0;
               else if (mclk_tick) stg_q[gi] <= en_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)         stg_q[gi] <= 1'b0;
               else if (mclk_tick) stg_q[gi] <= stg_q[gi-1];
            end
         end
      end
   endgenerate

   assign en_ok = stg_q[STAGES-1];
endmodule

// File: rtl/gpd_divider.sv
module gpd_divider #(
   parameter int NW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mclk_tick,
   input  logic          mclk_nxt,
   input  logic          div_bypass,
   input  logic [NW-1:0] n_code,
   input  logic          en_ok,
   output logic          clk_out
);
   localparam int CW = NW + 1;

   logic [CW-1:0] divisor;
   logic [CW-1:0] hi_cnt;
   logic [CW-1:0] last_cnt;
   logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
   logic          run_q, run_d;
   logic          pulse_q, pulse_d;
   logic          hold_hi;
   logic          out_d;

   always_comb begin
      divisor  = {1'b0, n_code} + CW'(2);
      hi_cnt   = divisor >> 1;
      last_cnt = divisor - CW'(1);
      cnt_inc  = (cnt_q >= last_cnt) ? '0 : cnt_q + CW'(1);
      hold_hi  = pulse_q && (cnt_inc != '0) && (cnt_inc < hi_cnt);

      run_d   = run_q;
      cnt_d   = cnt_q;
      pulse_d = pulse_q;

      if (mclk_tick) begin
         if (div_bypass) begin
            // gate toggles only at a prescaled rising boundary
            run_d   = en_ok;
            cnt_d   = '0;
            pulse_d = 1'b0;
         end else if (!run_q) begin
            run_d   = en_ok;
            cnt_d   = '0;
            pulse_d = en_ok;
         end else if (en_ok || hold_hi) begin
            cnt_d   = cnt_inc;
            pulse_d = (cnt_inc < hi_cnt);
         end else begin
            run_d   = 1'b0;
            cnt_d   = '0;
            pulse_d = 1'b0;
         end
      end

      out_d = div_bypass ? (run_d & mclk_nxt) : pulse_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         run_q   <= 1'b0;
         pulse_q <= 1'b0;
         clk_out <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         run_q   <= run_d;
         pulse_q <= pulse_d;
         clk_out <= out_d;
      end
   end
endmodule

// File: rtl/gated_prescale_div.sv
module gated_prescale_div
   import gdiv_pkg::*;
#(
   parameter int NW          = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_m,
   input  logic          cfg_pre_bypass,
   input  logic          cfg_div_bypass,
   input  logic [NW-1:0] cfg_n,
   input  logic          enable_async,
   output logic          clk_out,
   output logic          mclk_out
);
   generate
      if (NW < 2 || NW > 16) begin : g_bad_nw
         $error("gated_prescale_div: NW must lie in 2..16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gated_prescale_div: SYNC_STAGES must be at least 2");
      end
   endgenerate

   ps_sel_e ps_sel;
   logic    mclk_tick;
   logic    mclk_nxt;
   logic    en_ok;

   assign ps_sel = ps_decode(cfg_pre_bypass, cfg_m);

   gpd_prescaler u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (ps_sel),
      .mclk_tick (mclk_tick),
      .mclk_nxt  (mclk_nxt),
      .mclk_q    (mclk_out)
   );

   gpd_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .mclk_tick (mclk_tick),
      .en_async  (enable_async),
      .en_ok     (en_ok)
   );

   gpd_divider #(.NW(NW)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .mclk_tick  (mclk_tick),
      .mclk_nxt   (mclk_nxt),
      .div_bypass (cfg_div_bypass),
      .n_code     (cfg_n),
      .en_ok      (en_ok),
      .clk_out    (clk_out)
   );
endmodule

// File: rtl/gpd_checker.sv
module gpd_checker #(
   parameter int NW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_m,
   input logic          cfg_pre_bypass,
   input logic          cfg_div_bypass,
   input logic [NW-1:0] cfg_n,
   input logic          clk_out,
   input logic          mclk_out
);
   logic [15:0] half_w;
   logic [15:0] pulse_w;
   logic [15:0] mhi_q;
   logic [15:0] ohi_q;

   always_comb begin
      half_w  = cfg_pre_bypass ? 16'd1 : (cfg_m ? 16'd2 : 16'd4);
      pulse_w = cfg_div_bypass ? half_w
                               : 16'(((int'(cfg_n) + 2) / 2) * 2 * int'(half_w));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mhi_q <= '0;
         ohi_q <= '0;
      end else begin
         mhi_q <= mclk_out ? mhi_q + 16'd1 : '0;
         ohi_q <= clk_out  ? ohi_q + 16'd1 : '0;
      end
   end

   AST_MCLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(mclk_out) |-> (mhi_q == half_w)); // R1
   AST_OUT_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(clk_out) |-> (ohi_q == pulse_w)); // R7
   AST_RISE_ON_MCLK: assert property (@(posedge clk) disable iff (!rst_n) $rose(clk_out) |-> $rose(mclk_out)); // R4
   AST_BYPASS_INSIDE_MCLK: assert property (@(posedge clk) disable iff (!rst_n) (cfg_div_bypass && clk_out) |-> mclk_out); // R5
endmodule

bind gated_prescale_div gpd_checker #(.NW(NW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_m          (cfg_m),
   .cfg_pre_bypass (cfg_pre_bypass),
   .cfg_div_bypass (cfg_div_bypass),
   .cfg_n          (cfg_n),
   .clk_out        (clk_out),
   .mclk_out       (mclk_out)
);

// File: tb/gated_prescale_div_tb_top.sv
module gated_prescale_div_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NW         = 9;
   localparam int NVEC       = 7;
   // fields: [11] pre_bypass, [10] m, [9] div_bypass, [8:0] code
   localparam logic [11:0] VECS [NVEC] = '{
      {1'b1, 1'b0, 1'b0, 9'd0},
      {1'b0, 1'b1, 1'b0, 9'd1},
      {1'b0, 1'b0, 1'b0, 9'd5},
      {1'b1, 1'b0, 1'b0, 9'd511},
      {1'b0, 1'b1, 1'b1, 9'd37},
      {1'b1, 1'b0, 1'b1, 9'd0},
      {1'b1, 1'b0, 1'b0, 9'd4}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_m = 1'b0;
   logic          cfg_pre_bypass = 1'b1;
   logic          cfg_div_bypass = 1'b0;
   logic [NW-1:0] cfg_n = '0;
   logic          enable_async = 1'b0;
   logic          clk_out;
   logic          mclk_out;

   int total = 0;
   int bad = 0;
   int misalign = 0;
   bit done = 1'b0;
   logic prev_c = 1'b0;
   logic prev_m = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gated_prescale_div #(.NW(NW)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_m          (cfg_m),
      .cfg_pre_bypass (cfg_pre_bypass),
      .cfg_div_bypass (cfg_div_bypass),
      .cfg_n          (cfg_n),
      .enable_async   (enable_async),
      .clk_out        (clk_out),
      .mclk_out       (mclk_out)
   );

   // R4 monitor: every output rise must share its sample with an mclk_out rise
   always @(negedge clk) begin
      if (rst_n && clk_out && !prev_c && !(mclk_out && !prev_m)) misalign++;
      prev_c = clk_out;
      prev_m = mclk_out;
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int half_of(input logic [11:0] v);
      return v[11] ? 1 : (v[10] ? 2 : 4);
   endfunction

   function automatic logic pick(input int w);
      return (w != 0) ? mclk_out : clk_out;
   endfunction

   task automatic apply_cfg(input logic [11:0] v);
      rst_n = 1'b0;
      enable_async = 1'b0;
      {cfg_pre_bypass, cfg_m, cfg_div_bypass, cfg_n} = v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic meas(input int w, output int hi, output int lo);
      while (pick(w)) @(negedge clk);
      while (!pick(w)) @(negedge clk);
      hi = 0;
      while (pick(w)) begin hi++; @(negedge clk); end
      lo = 0;
      while (!pick(w)) begin lo++; @(negedge clk); end
   endtask

   // raise enable, expect output rise together with the third mclk_out rise (R6)
   task automatic enable_latency(input string tag);
      int   rises = 0;
      int   early = 0;
      logic pm;
      enable_async = 1'b1;
      pm = mclk_out;
      while (rises < 3) begin
         @(negedge clk);
         if (mclk_out && !pm) rises++;
         if (rises < 3 && clk_out) early++;
         pm = mclk_out;
      end
      check({tag, " early output"}, early, 0);
      check({tag, " rise at third mclk edge"}, int'(clk_out), 1);
   endtask

   task automatic count_high(input int cycles, output int highs, output int rises);
      logic pc;
      highs = 0;
      rises = 0;
      pc = clk_out;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (clk_out) highs++;
         if (clk_out && !pc) rises++;
         pc = clk_out;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int hi, lo, hs, rs, p, d;
      repeat (3) @(negedge clk);
      check("R9 clk_out in reset", int'(clk_out), 0);
      check("R9 mclk_out in reset", int'(mclk_out), 0);
      rst_n = 1'b1;
      count_high(40, hs, rs);
      check("R9 clk_out idle while disabled", hs, 0);
      hs = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (mclk_out) hs++;
      end
      check("R9 R1 mclk_out runs while disabled", hs, 20);

      for (int v = 0; v < NVEC; v++) begin
         apply_cfg(VECS[v]);
         enable_async = 1'b1;
         p = half_of(VECS[v]);
         d = int'(VECS[v][8:0]) + 2;
         meas(1, hi, lo);
         check($sformatf("R1 mclk high v%0d", v), hi, p);
         check($sformatf("R1 mclk low v%0d", v), lo, p);
         meas(0, hi, lo);
         if (VECS[v][9]) begin
            check($sformatf("R5 bypass high v%0d", v), hi, p);
            check($sformatf("R5 bypass low v%0d", v), lo, p);
         end else begin
            check($sformatf("R3 high width v%0d", v), hi, (d / 2) * 2 * p);
            check($sformatf("R2 period v%0d", v), hi + lo, d * 2 * p);
         end
      end

      // divide by 7, prescale 4: high 24 cycles, low 32 cycles
      apply_cfg({1'b0, 1'b0, 1'b0, 9'd5});
      repeat (10) @(negedge clk);
      enable_latency("R6 first enable");
      hi = 1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (clk_out) hi++;
      end
      enable_async = 1'b0;
      while (clk_out) begin
         @(negedge clk);
         if (clk_out) hi++;
      end
      check("R7 pulse completes after disable in high", hi, 24);
      count_high(224, hs, rs);
      check("R7 stays low after disable in high", hs, 0);

      enable_latency("R6 re-enable after high stop");
      while (clk_out) @(negedge clk);
      enable_async = 1'b0;
      count_high(224, hs, rs);
      check("R7 no pulse after disable in low", hs, 0);
      enable_latency("R6 re-enable after low stop");
      meas(0, hi, lo);
      check("R2 period after re-enable", hi + lo, 56);

      // divide-by-one, prescale 2
      apply_cfg({1'b0, 1'b1, 1'b1, 9'd37});
      enable_async = 1'b1;
      repeat (30) @(negedge clk);
      enable_async = 1'b0;
      count_high(80, hs, rs);
      check("R8 extra pulses after disable", rs, 2);
      count_high(40, hs, rs);
      check("R8 low after extra pulses", hs, 0);

      check("R4 rises aligned with mclk_out", misalign, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule